// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits on the external bus of a small 8-bit microcontroller. The controller sends the low byte of each address on the same port that later carries data. The high byte comes out on a separate port. A pulse on the address-latch-enable input marks the moment when the shared port holds the low address byte. The block holds that byte, joins it to the high byte to make a 16-bit address, and turns the address into active-low chip enables for four devices: a 32Kx8 RAM, a character LCD, a DAC and an ADC. The active-low read and write strobes pass straight through to the same devices.

The RAM takes the whole upper half of the address space. The three peripherals share the lower half and are told apart by only two low address bits. Each peripheral therefore repeats at many addresses. This is acceptable as long as no single address ever enables two devices. One of the four two-bit codes is left unused and enables nothing.

The low-byte hold stage is transparent while the latch enable is high. It keeps its value from the last clock edge at which the latch enable was high, so the shared port can carry data afterwards without changing the decoded enables.

Top module: `mbd_top`

## Requirements
- R1: After reset the held low byte is 0x00, so with the high port at 0x00 and the latch enable low, only the LCD enable is active, whatever the shared port carries.
- R2: The RAM enable `ram_ce_n` is low exactly when address bit 15 is 1, and no peripheral is enabled in that case.
- R3: The LCD enable `lcd_ce_n` is low exactly when address bits 15, 6 and 5 are all 0 (for example, addresses 0 to 31).
- R4: The DAC enable `dac_ce_n` is low exactly when bit 15 is 0, bit 6 is 0 and bit 5 is 1 (for example, address 32).
- R5: The ADC enable `adc_ce_n` is low exactly when bit 15 is 0, bit 6 is 1 and bit 5 is 0 (for example, address 64).
- R6: When bit 15 is 0 and bits 6 and 5 are both 1, all four enables are high.
- R7: For every one of the 65536 addresses, at most one enable is low.
- R8: While the latch enable is low, the decoded low byte is the value that was on the shared port at the last clock edge with the latch enable high. Later data on the shared port has no effect on the enables.
- R9: While the latch enable is high, the low byte follows the shared port in the same cycle, with no clock edge needed.
- R10: `rd_n` equals `rd_n_in` and `wr_n` equals `wr_n_in` in the same cycle, with no change in polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address latch enable, high while the shared port carries the low address |
| ad_port | input | 8 | Shared low-address / data port |
| hi_port | input | 8 | High address byte |
| rd_n_in | input | 1 | Read strobe from the controller, active low |
| wr_n_in | input | 1 | Write strobe from the controller, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| lcd_ce_n | output | 1 | LCD enable, active low |
| dac_ce_n | output | 1 | DAC enable, active low |
| adc_ce_n | output | 1 | ADC enable, active low |
| rd_n | output | 1 | Read strobe to the devices |
| wr_n | output | 1 | Write strobe to the devices |

## Verification
Every one of the 65536 addresses is applied twice.

The first time, the latch enable is high and the address is presented before any clock edge. This shows that the stage is transparent and not simply registered.

The second time, the latch enable is low and the inverted low byte is driven on the shared port. Any decoder that reads the live port instead of the held byte then selects a different device.

At both points the bench compares all four enables with the bit equations and confirms that at most one of them is low. The strobe inputs follow address bits during the sweep, so both polarities of each strobe are seen.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
   // Peripheral slots in the lower half, indexed by the select-field code
   typedef enum logic [1:0] {
      SLOT_LCD = 2'd0,
      SLOT_DAC = 2'd1,
      SLOT_ADC = 2'd2
   } slot_e;

   localparam int unsigned NUM_SLOTS = 3;
endpackage

// File: rtl/mbd_addr_hold.sv
module mbd_addr_hold #(
   parameter int unsigned LO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ale,
   input  logic [LO_W-1:0] port,
   output logic [LO_W-1:0] addr_lo
);
   if (LO_W < 1) begin : g_bad_w
      $error("mbd_addr_hold: LO_W must be at least 1");
   end

   logic [LO_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q <= '0;
      else if (ale) held_q <= port;
   end

   // transparent while ale high, held value otherwise
   assign addr_lo = ale ? port : held_q;

   // R9
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (held_q == $past(port)));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> (held_q == $past(held_q)));
endmodule

// File: rtl/mbd_sel_decode.sv
module mbd_sel_decode #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned SEL_LSB = 5,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned N_SLOTS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   output logic               mem_ce_n,
   output logic [N_SLOTS-1:0] slot_ce_n
);
   localparam int unsigned TOP_BIT = ADDR_W - 1;
   localparam int unsigned N_CODES = 1 << SEL_W;

   if (SEL_LSB + SEL_W > TOP_BIT) begin : g_bad_field
      $error("mbd_sel_decode: select field overlaps the memory bit");
   end
   if (N_SLOTS > N_CODES) begin : g_bad_slots
      $error("mbd_sel_decode: more slots than select codes");
   end

   logic             low_half;
   logic [SEL_W-1:0] code;

   assign low_half = !addr[TOP_BIT];
   assign code     = addr[SEL_LSB +: SEL_W];
   assign mem_ce_n = low_half;

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      assign slot_ce_n[g] = !(low_half && (code == SEL_W'(g)));
   end

   // R7
   at_most_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~{mem_ce_n, slot_ce_n}));

   // R6
   unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (low_half && (int'(code) >= N_SLOTS)) |-> (mem_ce_n && (&slot_ce_n)));
endmodule

// File: rtl/mbd_top.sv
module mbd_top #(
   parameter int unsigned LO_W    = 8,
   parameter int unsigned HI_W    = 8,
   parameter int unsigned SEL_LSB = 5,
   parameter int unsigned SEL_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ale,
   input  logic [LO_W-1:0] ad_port,
   input  logic [HI_W-1:0] hi_port,
   input  logic            rd_n_in,
   input  logic            wr_n_in,
   output logic            ram_ce_n,
   output logic            lcd_ce_n,
   output logic            dac_ce_n,
   output logic            adc_ce_n,
   output logic            rd_n,
   output logic            wr_n
);
   import mbd_pkg::*;

   localparam int unsigned ADDR_W = LO_W + HI_W;

   if (SEL_W < 2) begin : g_bad_sel
      $error("mbd_top: three peripherals need a select field of 2 bits or more");
   end

   logic [LO_W-1:0]      lo_byte;
   logic [ADDR_W-1:0]    full_addr;
   logic [NUM_SLOTS-1:0] slot_n;

   mbd_addr_hold #(.LO_W(LO_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .ale     (ale),
      .port    (ad_port),
      .addr_lo (lo_byte)
   );

   assign full_addr = {hi_port, lo_byte};

   mbd_sel_decode #(
      .ADDR_W  (ADDR_W),
      .SEL_LSB (SEL_LSB),
      .SEL_W   (SEL_W),
      .N_SLOTS (NUM_SLOTS)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (full_addr),
      .mem_ce_n  (ram_ce_n),
      .slot_ce_n (slot_n)
   );

   assign lcd_ce_n = slot_n[SLOT_LCD];
   assign dac_ce_n = slot_n[SLOT_DAC];
   assign adc_ce_n = slot_n[SLOT_ADC];

   assign rd_n = rd_n_in;
   assign wr_n = wr_n_in;

   // R10
   strobe_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n == rd_n_in) && (wr_n == wr_n_in));

   // R2
   ram_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_port[HI_W-1] |-> (!ram_ce_n && lcd_ce_n && dac_ce_n && adc_ce_n));
endmodule

// File: tb/mbd_top_tb.sv
module mbd_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ale = 1'b0;
   logic [7:0] ad_port = 8'h00;
   logic [7:0] hi_port = 8'h00;
   logic       rd_n_in = 1'b1;
   logic       wr_n_in = 1'b1;
   logic       ram_ce_n, lcd_ce_n, dac_ce_n, adc_ce_n, rd_n, wr_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mbd_top u_dut (
      .clk(clk), .rst_n(rst_n), .ale(ale), .ad_port(ad_port), .hi_port(hi_port),
      .rd_n_in(rd_n_in), .wr_n_in(wr_n_in), .ram_ce_n(ram_ce_n),
      .lcd_ce_n(lcd_ce_n), .dac_ce_n(dac_ce_n), .adc_ce_n(adc_ce_n),
      .rd_n(rd_n), .wr_n(wr_n)
   );

   // expected {ram, lcd, dac, adc}, active low, from the bit equations
   function automatic logic [3:0] expect_en(input logic [15:0] a);
      logic [3:0] e = 4'b1111;
      if (a[15])                   e[3] = 1'b0;
      else if (a[6:5] == 2'b00)    e[2] = 1'b0;
      else if (a[6:5] == 2'b01)    e[1] = 1'b0;
      else if (a[6:5] == 2'b10)    e[0] = 1'b0;
      return e;
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      if (a[15]) return "R2";
      case (a[6:5])
         2'b00:   return "R3";
         2'b01:   return "R4";
         2'b10:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check_en(input string tag, input logic [15:0] a);
      logic [3:0] act = {ram_ce_n, lcd_ce_n, dac_ce_n, adc_ce_n};
      logic [3:0] exp = expect_en(a);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s addr=%h act=%b exp=%b", tag, a, act, exp);
      end
      // R7 at most one enable low
      checks++;
      if ($countones(~act) > 1) begin
         errors++;
         $display("FAIL R7 addr=%h act=%b exp=at most one low", a, act);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%b exp=%b", tag, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state: held byte zero, live port ignored while ale low
      ad_port = 8'h77;
      repeat (3) @(negedge clk);
      #1 check_en("R1", 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      ad_port = 8'hE0;
      #1 check_en("R1", 16'h0000);

      for (int a = 0; a < 65536; a++) begin
         logic [15:0] ad = 16'(a);
         // transparent phase, checked before any edge: R9 (plus R2..R7)
         @(negedge clk);
         ale     = 1'b1;
         hi_port = ad[15:8];
         ad_port = ad[7:0];
         rd_n_in = ad[0];
         wr_n_in = ad[1];
         #1 check_en({"R9/", tag_of(ad)}, ad);
         // hold phase with data on the shared port: R8
         @(negedge clk);
         ale     = 1'b0;
         ad_port = ~ad[7:0];
         #1 check_en({"R8/", tag_of(ad)}, ad);
         if (ad[7:0] == 8'h00) begin
            // R10 strobe pass-through
            check_bit("R10 rd", rd_n, ad[0]);
            check_bit("R10 wr", wr_n, ad[1]);
         end
      end

      // R10 both polarities explicitly
      @(negedge clk);
      rd_n_in = 1'b0; wr_n_in = 1'b1;
      #1 check_bit("R10 rd", rd_n, 1'b0);
      check_bit("R10 wr", wr_n, 1'b1);
      rd_n_in = 1'b1; wr_n_in = 1'b0;
      #1 check_bit("R10 rd", rd_n, 1'b1);
      check_bit("R10 wr", wr_n, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule